// File: doc/BRIEF.md
# Media Access Gate

This block owns the two-bit media state of a memory device and decides, from that state, whether host memory traffic reaches the media and whether a mailbox command may run. Requests from elsewhere in the device move the state: an enable request marks the media ready, and a disable request marks it disabled. For example, a sanitize engine raises the disable request when it starts and the enable request when it finishes. The state and a mailbox-ready flag are presented as an 8-bit device status word.

While the media is disabled, memory reads still complete, but they return pseudo-random words from a 32-bit LFSR instead of media data. Memory writes are acknowledged but never reach the media. A fixed set of command classes from the mailbox decoder is answered with a reject strobe and a dedicated return code, and every other class passes through. The state machine has three states: NOT_READY (encoding 00, the reset state), READY (01) and DISABLED (11). Its four transitions are BRING_UP (NOT_READY to READY on enable), SHUT_EARLY (NOT_READY to DISABLED on disable), TAKE_DOWN (READY to DISABLED on disable) and RESTORE (DISABLED to READY on enable).

Top module: `media_access_gate`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted and after it is released, dev_status is 0x00, and rd_valid, wr_ack, cmd_reject, cmd_pass, media_rd_en and media_wr_en are all 0.
- R2: The media state sits in dev_status[3:2] with 00 = not ready, 01 = ready and 11 = disabled. A disable request moves it to 11 and an enable request moves it to 01, visible one clock after the request. When both requests arrive in the same cycle, disable wins.
- R3: A request that names the state already held leaves all of dev_status unchanged, and no request at all also leaves it unchanged.
- R4: Every change of media state also sets dev_status[4] (mailbox ready), which then stays set until reset. dev_status[7:5] and dev_status[1:0] always read 0.
- R5: In state 01, media_rd_en equals rd_req and media_wr_en equals wr_req in the same cycle. One cycle after rd_req, rd_valid is 1 and rd_data holds the media_rdata that was sampled with the request.
- R6: In state 11, media_rd_en stays 0. A read still completes, with rd_valid one cycle later, and rd_data carries the LFSR value.
- R7: In any state, wr_ack follows wr_req by one cycle. In state 11, media_wr_en stays 0.
- R8: In state 00, user data is inaccessible: media_rd_en and media_wr_en stay 0, and reads return all-zero data. Commands are not rejected, because only 11 counts as disabled.
- R9: The LFSR starts at seed 0x1D5B2C97 on reset and advances on every rd_req in every state, as next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. A disabled read returns the value held before that advance.
- R10: In state 11, a command of class 1 to 8 is rejected one cycle after cmd_valid, with cmd_reject = 1, cmd_pass = 0 and cmd_rc = 0x0024. The classes are: 1 event-record read, 2 log read, 3 partition info, 4 label-area get, 5 label-area set, 6 poison list, 7 poison inject, 8 poison clear.
- R11: Classes 0 and 9 to 15 in state 11, and every class in states 00 and 01, give cmd_pass = 1, cmd_reject = 0 and cmd_rc = 0 one cycle later. Without cmd_valid, both strobes stay 0.
- R12: Gating decisions use the state held before the clock edge, so a request in the same cycle as a read, write or command does not affect how that access is treated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Request to mark media ready |
| dis_req | input | 1 | Request to mark media disabled |
| dev_status | output | 8 | Device status word: [3:2] media state, [4] mailbox ready |
| rd_req | input | 1 | Host memory read request |
| media_rdata | input | DATA_W | Data returned by media for the current read |
| media_rd_en | output | 1 | Read strobe forwarded to media |
| rd_valid | output | 1 | Read completion, one cycle after rd_req |
| rd_data | output | DATA_W | Read completion data |
| wr_req | input | 1 | Host memory write request |
| media_wr_en | output | 1 | Write enable forwarded to media |
| wr_ack | output | 1 | Write completion, one cycle after wr_req |
| cmd_valid | input | 1 | Mailbox decoder presents a command |
| cmd_class | input | CLS_W | Command class code |
| cmd_reject | output | 1 | Command refused because media is disabled |
| cmd_pass | output | 1 | Command allowed to run |
| cmd_rc | output | RC_W | Return code, 0x0024 on reject, else 0 |

## Verification
A wrong state register shows up one clock after the faulty edge in two places: in dev_status[3:2], and in the media strobes on the next read or write, since they fall to 0 or rise against the expected state. A lost or stuck mailbox-ready flag is visible in dev_status[4] on the cycle after the first transition. An LFSR that steps wrongly is detected on the first disabled read, because the bench predicts every word from the seed and the count of reads. A wrong class mask is caught by the sweep, in which every class meets every state under every request combination.

// File: rtl/media_gate_pkg.sv
`timescale 1ns/1ps
package media_gate_pkg;

    // Media state encoding, placed in status bits [3:2]
    typedef enum logic [1:0] {
        MS_NOT_READY = 2'b00,
        MS_READY     = 2'b01,
        MS_DISABLED  = 2'b11
    } media_state_e;

    // Decoded request, disable has priority
    typedef enum logic [1:0] {
        REQ_NONE    = 2'b00,
        REQ_ENABLE  = 2'b01,
        REQ_DISABLE = 2'b10
    } media_req_e;

    localparam int STATUS_W     = 8;
    localparam int MEDIA_LSB    = 2;
    localparam int MBOX_RDY_BIT = 4;
    localparam int LFSR_W       = 32;

endpackage

// File: rtl/media_state_fsm.sv
`timescale 1ns/1ps
module media_state_fsm
    import media_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_req,
    input  logic                dis_req,
    output media_state_e        state,
    output logic [STATUS_W-1:0] status_word
);

    media_state_e state_q;
    media_state_e state_d;
    media_req_e   req;
    logic         mbox_rdy_q;

    // Request decode: disable outranks enable
    always_comb begin
        if (dis_req)      req = REQ_DISABLE;
        else if (en_req)  req = REQ_ENABLE;
        else              req = REQ_NONE;
    end

    // Transitions BRING_UP, SHUT_EARLY, TAKE_DOWN, RESTORE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_NOT_READY: begin
                if (req == REQ_DISABLE)     state_d = MS_DISABLED;
                else if (req == REQ_ENABLE) state_d = MS_READY;
            end
            MS_READY: begin
                if (req == REQ_DISABLE)     state_d = MS_DISABLED;
            end
            MS_DISABLED: begin
                if (req == REQ_ENABLE)      state_d = MS_READY;
            end
            default: state_d = MS_NOT_READY;
        endcase
    end

    // State register; a real change of state also raises mailbox ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= MS_NOT_READY;
            mbox_rdy_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) mbox_rdy_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        state                         = state_q;
        status_word                   = '0;
        status_word[MEDIA_LSB +: 2]   = state_q;
        status_word[MBOX_RDY_BIT]     = mbox_rdy_q;
    end

endmodule

// File: rtl/media_rand_lfsr.sv
`timescale 1ns/1ps
module media_rand_lfsr
    import media_gate_pkg::*;
#(
    parameter int                OUT_W = 32,
    parameter logic [LFSR_W-1:0] SEED  = 32'h1D5B_2C97
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] value
);

    localparam int REPS = (OUT_W + LFSR_W - 1) / LFSR_W;

    logic [LFSR_W-1:0]      sreg;
    logic                   fb;
    logic [REPS*LFSR_W-1:0] wide;

    // Taps 32,22,2,1 give a maximal-length sequence
    assign fb = sreg[31] ^ sreg[21] ^ sreg[1] ^ sreg[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sreg <= SEED;
        else if (adv) sreg <= {sreg[LFSR_W-2:0], fb};
    end

    // Widen or narrow the word to the data width
    generate
        for (genvar k = 0; k < REPS; k++) begin : g_rep
            assign wide[k*LFSR_W +: LFSR_W] = sreg;
        end
    endgenerate

    assign value = wide[OUT_W-1:0];

endmodule

// File: rtl/media_data_gate.sv
`timescale 1ns/1ps
module media_data_gate
    import media_gate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  media_state_e      state,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] media_rdata,
    input  logic [DATA_W-1:0] rand_word,
    output logic              media_rd_en,
    output logic              media_wr_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack
);

    logic              live;
    logic [DATA_W-1:0] rd_sel;

    assign live        = (state == MS_READY);
    assign media_rd_en = rd_req && live;
    assign media_wr_en = wr_req && live;

    // Read source per state
    always_comb begin
        unique case (state)
            MS_READY:    rd_sel = media_rdata;
            MS_DISABLED: rd_sel = rand_word;
            default:     rd_sel = '0;
        endcase
    end

    // Completions are returned for every access, whatever the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wr_ack   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            wr_ack   <= wr_req;
            if (rd_req) rd_data <= rd_sel;
        end
    end

endmodule

// File: rtl/media_cmd_filter.sv
`timescale 1ns/1ps
module media_cmd_filter #(
    parameter int                      CLS_W      = 4,
    parameter int                      RC_W       = 16,
    parameter logic [(1<<CLS_W)-1:0]   GATED_MASK = 16'h01FE,
    parameter logic [RC_W-1:0]         REJ_CODE   = 16'h0024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CLS_W-1:0] cmd_class,
    input  logic             media_off,
    output logic             cmd_reject,
    output logic             cmd_pass,
    output logic [RC_W-1:0]  cmd_rc
);

    localparam int NCLS = 1 << CLS_W;

    logic [NCLS-1:0] class_hit;
    logic            blocked;

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            assign class_hit[c] = GATED_MASK[c] && (cmd_class == CLS_W'(c));
        end
    endgenerate

    assign blocked = cmd_valid && media_off && (|class_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_reject <= 1'b0;
            cmd_pass   <= 1'b0;
            cmd_rc     <= '0;
        end else begin
            cmd_reject <= blocked;
            cmd_pass   <= cmd_valid && !blocked;
            cmd_rc     <= blocked ? REJ_CODE : '0;
        end
    end

endmodule

// File: rtl/media_access_gate.sv
`timescale 1ns/1ps
module media_access_gate
    import media_gate_pkg::*;
#(
    parameter int                    DATA_W     = 32,
    parameter int                    CLS_W      = 4,
    parameter int                    RC_W       = 16,
    parameter logic [(1<<CLS_W)-1:0] GATED_MASK = 16'h01FE,
    parameter logic [RC_W-1:0]       REJ_CODE   = 16'h0024,
    parameter logic [LFSR_W-1:0]     LFSR_SEED  = 32'h1D5B_2C97
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    output logic [7:0]        dev_status,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] media_rdata,
    output logic              media_rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    output logic              media_wr_en,
    output logic              wr_ack,
    input  logic              cmd_valid,
    input  logic [CLS_W-1:0]  cmd_class,
    output logic              cmd_reject,
    output logic              cmd_pass,
    output logic [RC_W-1:0]   cmd_rc
);

    media_state_e      state;
    logic [DATA_W-1:0] rand_word;

    media_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req      (en_req),
        .dis_req     (dis_req),
        .state       (state),
        .status_word (dev_status)
    );

    media_rand_lfsr #(
        .OUT_W (DATA_W),
        .SEED  (LFSR_SEED)
    ) u_rand (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rd_req),
        .value (rand_word)
    );

    media_data_gate #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .media_rdata (media_rdata),
        .rand_word   (rand_word),
        .media_rd_en (media_rd_en),
        .media_wr_en (media_wr_en),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .wr_ack      (wr_ack)
    );

    media_cmd_filter #(
        .CLS_W      (CLS_W),
        .RC_W       (RC_W),
        .GATED_MASK (GATED_MASK),
        .REJ_CODE   (REJ_CODE)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_class  (cmd_class),
        .media_off  (state == MS_DISABLED),
        .cmd_reject (cmd_reject),
        .cmd_pass   (cmd_pass),
        .cmd_rc     (cmd_rc)
    );

endmodule

// File: rtl/media_access_gate_chk.sv
`timescale 1ns/1ps
module media_access_gate_chk #(
    parameter int                    CLS_W      = 4,
    parameter int                    RC_W       = 16,
    parameter logic [(1<<CLS_W)-1:0] GATED_MASK = 16'h01FE,
    parameter logic [RC_W-1:0]       REJ_CODE   = 16'h0024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_req,
    input logic             dis_req,
    input logic [7:0]       dev_status,
    input logic             rd_req,
    input logic             media_rd_en,
    input logic             rd_valid,
    input logic             wr_req,
    input logic             media_wr_en,
    input logic             wr_ack,
    input logic             cmd_valid,
    input logic [CLS_W-1:0] cmd_class,
    input logic             cmd_reject,
    input logic             cmd_pass,
    input logic [RC_W-1:0]  cmd_rc
);

    assert_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> (dev_status[3:2] == 2'b11));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_req && !dis_req) |=> $stable(dev_status));

    assert_mbox_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req || dis_req) |=> dev_status[4]);

    assert_rd_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_rd_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        media_rd_en |-> (dev_status[3:2] == 2'b01));

    assert_wr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        media_wr_en |-> (dev_status[3:2] == 2'b01));

    assert_wr_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_ack);

    assert_no_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dev_status[3:2] != 2'b11) |=> (cmd_pass && !cmd_reject));

    assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dev_status[3:2] == 2'b11 && GATED_MASK[cmd_class])
            |=> (cmd_reject && cmd_rc == REJ_CODE));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_reject, cmd_pass}));

endmodule

bind media_access_gate media_access_gate_chk #(
    .CLS_W      (CLS_W),
    .RC_W       (RC_W),
    .GATED_MASK (GATED_MASK),
    .REJ_CODE   (REJ_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_req      (en_req),
    .dis_req     (dis_req),
    .dev_status  (dev_status),
    .rd_req      (rd_req),
    .media_rd_en (media_rd_en),
    .rd_valid    (rd_valid),
    .wr_req      (wr_req),
    .media_wr_en (media_wr_en),
    .wr_ack      (wr_ack),
    .cmd_valid   (cmd_valid),
    .cmd_class   (cmd_class),
    .cmd_reject  (cmd_reject),
    .cmd_pass    (cmd_pass),
    .cmd_rc      (cmd_rc)
);

// File: tb/media_access_gate_tb.sv
`timescale 1ns/1ps
module media_access_gate_tb;

    localparam logic [15:0] REJ  = 16'h0024;
    localparam logic [31:0] SEED = 32'h1D5B_2C97;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 0, dis_req = 0, rd_req = 0, wr_req = 0, cmd_valid = 0;
    logic [31:0] media_rdata = '0;
    logic [3:0]  cmd_class = '0;
    logic [7:0]  dev_status;
    logic        media_rd_en, rd_valid, media_wr_en, wr_ack, cmd_reject, cmd_pass;
    logic [31:0] rd_data;
    logic [15:0] cmd_rc;

    always #2.5 clk = ~clk;

    media_access_gate u_dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .dev_status(dev_status), .rd_req(rd_req), .media_rdata(media_rdata),
        .media_rd_en(media_rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .media_wr_en(media_wr_en), .wr_ack(wr_ack),
        .cmd_valid(cmd_valid), .cmd_class(cmd_class), .cmd_reject(cmd_reject),
        .cmd_pass(cmd_pass), .cmd_rc(cmd_rc)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Bench model of the requirements
    logic [1:0]  m_media;
    logic        m_mbox;
    logic [31:0] m_lfsr;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic bit gated(input logic [3:0] c);
        return (c >= 4'd1) && (c <= 4'd8);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_req = 0; dis_req = 0; rd_req = 0; wr_req = 0; cmd_valid = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_media = 2'b00; m_mbox = 1'b0; m_lfsr = SEED;
        #1;
        chk("R1", "dev_status", {24'h0, dev_status}, 32'h0);
        chk("R1", "rd_valid", {31'h0, rd_valid}, 32'h0);
        chk("R1", "wr_ack", {31'h0, wr_ack}, 32'h0);
        chk("R1", "strobes", {30'h0, cmd_reject, cmd_pass}, 32'h0);
        chk("R1", "media_en", {30'h0, media_rd_en, media_wr_en}, 32'h0);
    endtask

    task automatic cycle(input bit en, input bit dis, input bit rd, input bit wr,
                         input bit cv, input logic [3:0] cls, input logic [31:0] md);
        logic [1:0]  nm;
        logic [31:0] exp_rd;
        bit          exp_rej;
        string       rq;
        string       rdq;
        @(negedge clk);
        en_req = en; dis_req = dis; rd_req = rd; wr_req = wr;
        cmd_valid = cv; cmd_class = cls; media_rdata = md;
        #1;
        rq = (m_media == 2'b01) ? "R5" : (m_media == 2'b11) ? "R7" : "R8";
        chk(rq, "media_wr_en", {31'h0, media_wr_en}, {31'h0, wr && m_media == 2'b01});
        rq = (m_media == 2'b01) ? "R5" : (m_media == 2'b11) ? "R6" : "R8";
        chk(rq, "media_rd_en", {31'h0, media_rd_en}, {31'h0, rd && m_media == 2'b01});
        nm = dis ? 2'b11 : (en ? 2'b01 : m_media);
        exp_rd = (m_media == 2'b01) ? md : (m_media == 2'b11) ? m_lfsr : 32'h0;
        rdq = (m_media == 2'b01) ? "R5" : (m_media == 2'b11) ? "R6,R9" : "R8";
        if (en || dis) rdq = {rdq, " R12"};
        @(posedge clk);
        #1;
        rq = ((en || dis) && nm == m_media) ? "R3" : (en || dis) ? "R2" : "R3";
        chk(rq, "media field", {30'h0, dev_status[3:2]}, {30'h0, nm});
        chk("R4", "mbox ready", {31'h0, dev_status[4]}, {31'h0, m_mbox | (nm != m_media)});
        chk("R4", "zero bits", {27'h0, dev_status[7:5], dev_status[1:0]}, 32'h0);
        chk("R5", "rd_valid", {31'h0, rd_valid}, {31'h0, rd});
        if (rd) chk(rdq, "rd_data", rd_data, exp_rd);
        chk("R7", "wr_ack", {31'h0, wr_ack}, {31'h0, wr});
        exp_rej = cv && (m_media == 2'b11) && gated(cls);
        rq = exp_rej ? "R10" : "R11";
        if (en || dis) rq = {rq, " R12"};
        chk(rq, "cmd_reject", {31'h0, cmd_reject}, {31'h0, exp_rej});
        chk(rq, "cmd_pass", {31'h0, cmd_pass}, {31'h0, cv && !exp_rej});
        chk(rq, "cmd_rc", {16'h0, cmd_rc}, exp_rej ? {16'h0, REJ} : 32'h0);
        m_mbox  = m_mbox | (nm != m_media);
        m_media = nm;
        if (rd) m_lfsr = lfsr_next(m_lfsr);
        en_req = 0; dis_req = 0; rd_req = 0; wr_req = 0; cmd_valid = 0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // Sweep: every start state x every request pair x every class
        for (int s = 0; s < 3; s++) begin
            for (int rqc = 0; rqc < 4; rqc++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [3:0]  cl;
                    logic [31:0] md;
                    cl = 4'(c);
                    md = 32'hA500_0000 ^ (32'(c) * 32'h0103_0507) ^ 32'(rqc);
                    do_reset();
                    if (s == 1) cycle(1, 0, 0, 0, 0, 4'h0, 32'h0);
                    if (s == 2) cycle(0, 1, 0, 0, 0, 4'h0, 32'h0);
                    cycle(rqc[0], rqc[1], cl[0], cl[1], 1, cl, md);
                    cycle(0, 0, 1, 1, 1, cl, ~md);
                    cycle(0, 0, 0, 0, 0, 4'h0, 32'h0);
                end
            end
        end

        // LFSR stream: reads before disable also advance it (R9)
        do_reset();
        for (int i = 0; i < 5; i++) cycle(0, 0, 1, 0, 0, 4'h0, 32'h1234_0000 + 32'(i));
        cycle(0, 1, 0, 0, 0, 4'h0, 32'h0);
        for (int i = 0; i < 300; i++) cycle(0, 0, 1, i[0], 0, 4'h0, 32'h0);

        // Round trips and redundant requests (R2, R3, R4)
        cycle(1, 0, 1, 1, 1, 4'd3, 32'hDEAD_BEEF);
        cycle(1, 0, 1, 1, 1, 4'd3, 32'hCAFE_F00D);
        cycle(0, 1, 1, 1, 1, 4'd6, 32'h0BAD_0001);
        cycle(0, 1, 1, 1, 1, 4'd6, 32'h0BAD_0002);
        cycle(1, 1, 1, 0, 1, 4'd8, 32'h0);
        cycle(1, 0, 0, 0, 1, 4'd9, 32'h0);
        cycle(0, 0, 1, 1, 1, 4'd8, 32'h5555_AAAA);

        finished = 1;
        summary();
        $finish;
    end

endmodule